// File: doc/BRIEF.md
# Aligned Transfer Command Splitter

This block sits on the host side of a serial memory link and turns one memory access request (start address, byte count and direction) into the list of link commands needed to carry it out. Each command carries an opcode, a 32-bit target address and a byte count. The rules for choosing commands keep every command naturally aligned to its own size and use as few commands as those rules allow. The block does not move any data. It only plans the commands and hands them out one at a time.

A request is accepted with a valid/ready handshake while the block is idle. The commands are then offered on a second valid/ready handshake. The address advances by the size of each accepted command until the planned length is used up, and a one-cycle completion pulse follows. Requests that cannot be served are refused with a one-cycle error pulse and produce no commands. For writes with an odd byte count, the plan grows by one byte so that the far side can append a zero byte. The splitter itself does not generate that byte.

Top module: `xfer_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `cmd_valid`, `done` and `err` are 0.
- R2: With `a = addr mod 8`, a 2-byte command is chosen when `a` is 2 or 6, or when exactly 2 bytes remain. Its opcode is 0 for a read and 1 for a write, and `cmd_len` = 2.
- R3: If R2 does not apply, a 4-byte command is chosen when `a` is 4 or when 6 or fewer bytes remain. Its opcode is 2 for a read and 3 for a write, and `cmd_len` = 4.
- R4: In every other case a burst command is chosen. Its opcode is 4 for a read and 5 for a write. Its length is the remaining count rounded down to a multiple of 8, limited to at most 240.
- R5: The first command's address is the request address. Each later command's address is the previous address plus the previous length. The lengths add up to the planned length. For example, a 260-byte read from 0x60030002 yields (0x..02,2), (0x..04,4), (0x..08,240), (0x..F8,8), (0x..100,4), (0x..104,2).
- R6: A request whose address has bit 0 set is refused, for reads and writes alike. `err` pulses for one cycle in the cycle after acceptance, and no command is issued.
- R7: A read request with an odd byte count is refused in the same way as in R6.
- R8: A write request with an odd byte count is planned as that count plus one.
- R9: A request whose planned length is zero issues no command. `done` pulses in the cycle after acceptance.
- R10: `done` is a one-cycle pulse in the cycle after the last command is accepted. It stays low while commands remain.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_op`, `cmd_addr` and `cmd_len` hold their values.
- R12: `req_ready` is 0 while commands are pending. A `req_valid` asserted during that time is ignored and does not disturb the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 32 | Start address |
| req_len | input | 16 | Byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken |
| cmd_op | output | 3 | Command opcode |
| cmd_addr | output | 32 | Command address |
| cmd_len | output | 8 | Command byte count |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
The hardest case to reach is a request that is still in progress while the consumer stalls and the requester keeps asserting a new request. In that situation the held command, the ignored request and the advancing address all interact. The bench reaches it in two steps. It holds `req_valid` high with a different address during the first command of the 260-byte example. It also withholds `cmd_ready` on every other command of a 1000-byte transfer, which repeats the 240-byte cap several times. In both cases every command is compared with a model built from the selection rules.

// File: rtl/splitter_pkg.sv
// Package: shared types for the command splitter.
// Assumes the opcode base values are 0, 2 and 4 for the three command sizes,
// with the write opcode one above the read opcode.
package splitter_pkg;

    typedef enum logic [1:0] {
        KIND_HALF  = 2'd0,
        KIND_WORD  = 2'd1,
        KIND_BURST = 2'd2
    } cmd_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } split_state_e;

    // Read opcode for each command kind; a write adds one.
    function automatic logic [2:0] kind_base_op(cmd_kind_e k);
        case (k)
            KIND_HALF:  kind_base_op = 3'd0;
            KIND_WORD:  kind_base_op = 3'd2;
            default:    kind_base_op = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/req_check.sv
// Module: req_check
// Validates an incoming request and works out the length to plan.
// Assumes: odd addresses are never allowed; odd lengths are refused for reads
// and rounded up by one byte for writes.
module req_check #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              is_write,
    output logic              reject,
    output logic [LEN_W:0]    planned_len
);

    // Refuse unaligned starts and odd-length reads.
    always_comb begin
        reject = addr[0] | (~is_write & len[0]);
    end

    // Pad odd write lengths to the next even count.
    always_comb begin
        planned_len = {1'b0, len} + {{LEN_W{1'b0}}, (is_write & len[0])};
    end

endmodule

// File: rtl/cmd_select.sv
// Module: cmd_select
// Picks the next command from the low address bits and the bytes remaining.
// Assumes the address is even and remain is even and nonzero when it is used.
module cmd_select
    import splitter_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 240,
    parameter int CNT_W     = 8
) (
    input  logic [2:0]       align,
    input  logic [LEN_W:0]   remain,
    input  logic             is_write,
    output logic [2:0]       op,
    output logic [CNT_W-1:0] nbytes
);

    localparam logic [LEN_W:0] BURST_CAP = (LEN_W+1)'(BURST_MAX);
    localparam logic [LEN_W:0] WORD_LIM  = (LEN_W+1)'(6);
    localparam logic [LEN_W:0] HALF_LEN  = (LEN_W+1)'(2);

    cmd_kind_e      kind;
    logic [LEN_W:0] rounded;

    // Priority rule: 2-byte first, then 4-byte, then burst.
    always_comb begin
        if (align == 3'd2 || align == 3'd6 || remain == HALF_LEN)
            kind = KIND_HALF;
        else if (align == 3'd4 || remain <= WORD_LIM)
            kind = KIND_WORD;
        else
            kind = KIND_BURST;
    end

    // Burst size: remaining count rounded down to 8, capped.
    always_comb begin
        rounded = {remain[LEN_W:3], 3'b000};
        if (rounded > BURST_CAP)
            rounded = BURST_CAP;
    end

    // Byte count and opcode for the selected kind.
    always_comb begin
        case (kind)
            KIND_HALF:  nbytes = CNT_W'(2);
            KIND_WORD:  nbytes = CNT_W'(4);
            default:    nbytes = rounded[CNT_W-1:0];
        endcase
        op = kind_base_op(kind) | {2'b00, is_write};
    end

endmodule

// File: rtl/xfer_splitter.sv
// Module: xfer_splitter
// Top of the command splitter: accepts a request while idle, then issues
// aligned commands one per handshake until the planned length is used up.
// Assumes cmd_ready may be withheld for any number of cycles.
module xfer_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 240,
    parameter int CNT_W     = $clog2(BURST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              done,
    output logic              err
);

    localparam logic [LEN_W:0] ZERO_LEN = '0;

    split_state_e      state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W:0]    remain;
    logic              cur_write;
    logic              done_q;
    logic              err_q;

    logic              reject;
    logic [LEN_W:0]    planned_len;
    logic              take_req;
    logic              take_cmd;
    logic [LEN_W:0]    step;

    req_check #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_check (
        .addr        (req_addr),
        .len         (req_len),
        .is_write    (req_write),
        .reject      (reject),
        .planned_len (planned_len)
    );

    cmd_select #(
        .LEN_W     (LEN_W),
        .BURST_MAX (BURST_MAX),
        .CNT_W     (CNT_W)
    ) u_select (
        .align    (cur_addr[2:0]),
        .remain   (remain),
        .is_write (cur_write),
        .op       (cmd_op),
        .nbytes   (cmd_len)
    );

    // Handshake qualifiers and the step size of the current command.
    always_comb begin
        req_ready = (state == ST_IDLE);
        cmd_valid = (state == ST_BUSY);
        take_req  = req_valid & req_ready;
        take_cmd  = cmd_valid & cmd_ready;
        step      = (LEN_W+1)'(cmd_len);
        cmd_addr  = cur_addr;
        done      = done_q;
        err       = err_q;
    end

    // Request walk: load on accept, advance per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            cur_write <= 1'b0;
        end else if (take_req) begin
            cur_addr  <= req_addr;
            remain    <= planned_len;
            cur_write <= req_write;
            if (!reject && planned_len != ZERO_LEN)
                state <= ST_BUSY;
        end else if (take_cmd) begin
            cur_addr <= cur_addr + ADDR_W'(cmd_len);
            remain   <= remain - step;
            if (remain == step)
                state <= ST_IDLE;
        end
    end

    // Completion and refusal pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (take_req & ~reject & (planned_len == ZERO_LEN))
                    | (take_cmd & (remain == step));
            err_q  <= take_req & reject;
        end
    end

    // Stalled command must not change.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
                                    && $stable(cmd_addr) && $stable(cmd_len));

    // Small commands are aligned to their own size.
    assert_small_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_len < CNT_W'(8) |->
            (cmd_len == CNT_W'(2) && !cmd_addr[0] && cmd_op[2:1] == 2'd0)
         || (cmd_len == CNT_W'(4) && cmd_addr[1:0] == 2'd0 && cmd_op[2:1] == 2'd1));

    // Bursts are 8-aligned, a multiple of 8 and within the cap.
    assert_burst_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_len >= CNT_W'(8) |->
            cmd_addr[2:0] == 3'd0 && cmd_len[2:0] == 3'd0
            && cmd_len <= CNT_W'(BURST_MAX) && cmd_op[2:1] == 2'd2);

    // A command never runs past the planned length.
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (LEN_W+1)'(cmd_len) <= remain);

    // A refused request leaves the block idle with no completion.
    assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_valid && !done && req_ready);

    // Completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // No new request is taken while commands are pending.
    assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

endmodule

// File: tb/test_xfer_splitter.sv
// Directed bench for xfer_splitter; every command is compared with a model
// derived from the selection rules.
module test_xfer_splitter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic        req_write;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_len;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xfer_splitter i_xfer_splitter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_write (req_write),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .done      (done),
        .err       (err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model of the selection rules (R2, R3, R4).
    task automatic model(input longint a, input longint r, input bit wr,
                         output int op, output int n);
        int al;
        al = int'(a % 8);
        if (al == 2 || al == 6 || r == 2) begin
            op = 0; n = 2;
        end else if (al == 4 || r <= 6) begin
            op = 2; n = 4;
        end else begin
            op = 4; n = int'((r / 8) * 8);
            if (n > 240) n = 240;
        end
        op = op + (wr ? 1 : 0);
    endtask

    // Issue one request and follow it to the end, checking every command.
    task automatic run_req(input logic [31:0] a, input int len, input bit wr,
                           input bit stall, input bit poke, input string tag,
                           output int ncmd);
        bit     refuse;
        longint planned, ea, er;
        int     eop, elen, guard;
        refuse  = a[0] || (!wr && len[0]);
        planned = wr ? len + (len % 2) : len;
        ncmd = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", {tag, " ready when idle"}, req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_write = wr;
        @(negedge clk);
        if (poke) begin
            req_addr = 32'h1234_5671; req_len = 16'd3; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        if (refuse) begin
            chk(err == 1'b1, a[0] ? "R6" : "R7", {tag, " err pulse"}, err, 1);
            chk(cmd_valid == 1'b0, a[0] ? "R6" : "R7", {tag, " no command"}, cmd_valid, 0);
            @(negedge clk);
            chk(err == 1'b0 && cmd_valid == 1'b0, a[0] ? "R6" : "R7",
                {tag, " err clears, still no command"}, {err, cmd_valid}, 0);
            return;
        end
        if (planned == 0) begin
            chk(done == 1'b1 && cmd_valid == 1'b0, "R9", {tag, " immediate done"},
                {done, cmd_valid}, 2'b10);
            @(negedge clk);
            chk(done == 1'b0, "R9", {tag, " done single cycle"}, done, 0);
            return;
        end
        ea = a; er = planned; guard = 0;
        while (er > 0 && guard < 500) begin
            guard++;
            model(ea, er, wr, eop, elen);
            chk(cmd_valid == 1'b1, "R5", {tag, " command pending"}, cmd_valid, 1);
            chk(cmd_op == 3'(eop), eop[2] ? "R4" : (eop[1] ? "R3" : "R2"),
                {tag, " opcode"}, cmd_op, eop);
            chk(cmd_len == 8'(elen), eop[2] ? "R4" : (eop[1] ? "R3" : "R2"),
                {tag, " length"}, cmd_len, elen);
            chk(cmd_addr == 32'(ea), "R5", {tag, " address"}, cmd_addr, ea);
            if (stall && (ncmd % 2 == 0)) begin
                @(negedge clk);
                chk(cmd_valid && cmd_op == 3'(eop) && cmd_len == 8'(elen)
                    && cmd_addr == 32'(ea), "R11", {tag, " held while stalled"},
                    cmd_addr, ea);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            req_valid = 1'b0;
            ea = ea + elen; er = er - elen; ncmd++;
            if (er > 0)
                chk(done == 1'b0, "R10", {tag, " no early done"}, done, 0);
        end
        chk(done == 1'b1 && cmd_valid == 1'b0, "R10", {tag, " done after last"},
            {done, cmd_valid}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R10", {tag, " done is a pulse"}, done, 0);
    endtask

    task automatic t_reset();
        req_valid = 0; req_addr = 0; req_len = 0; req_write = 0; cmd_ready = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(cmd_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1",
            "outputs quiet after reset", {cmd_valid, done, err}, 0);
    endtask

    task automatic t_example();
        int n;
        run_req(32'h6003_0002, 260, 1'b0, 1'b0, 1'b1, "R5 260-byte read", n);
        chk(n == 6, "R5", "260-byte read command count", n, 6);
    endtask

    task automatic t_small();
        int n;
        run_req(32'h5000_0000, 8, 1'b1, 1'b0, 1'b0, "R4 single burst write", n);
        chk(n == 1, "R4", "8-byte write count", n, 1);
        run_req(32'h5000_0010, 6, 1'b1, 1'b0, 1'b0, "R3 word then half", n);
        chk(n == 2, "R3", "6-byte write count", n, 2);
        run_req(32'h5000_0020, 2, 1'b0, 1'b0, 1'b0, "R2 two left", n);
        chk(n == 1, "R2", "2-byte read count", n, 1);
        run_req(32'h5000_0006, 4, 1'b0, 1'b0, 1'b0, "R2 align6", n);
        chk(n == 2, "R2", "align-6 read count", n, 2);
    endtask

    task automatic t_pad();
        int n;
        run_req(32'h5000_0040, 7, 1'b1, 1'b0, 1'b0, "R8 odd write", n);
        chk(n == 1, "R8", "odd write padded to one burst", n, 1);
    endtask

    task automatic t_refuse();
        int n;
        run_req(32'h5000_0001, 8, 1'b1, 1'b0, 1'b0, "R6 odd addr write", n);
        run_req(32'h5000_0003, 8, 1'b0, 1'b0, 1'b0, "R6 odd addr read", n);
        run_req(32'h5000_0000, 9, 1'b0, 1'b0, 1'b0, "R7 odd read len", n);
    endtask

    task automatic t_zero();
        int n;
        run_req(32'h5000_0100, 0, 1'b0, 1'b0, 1'b0, "R9 zero read", n);
        run_req(32'h5000_0104, 0, 1'b1, 1'b0, 1'b0, "R9 zero write", n);
    endtask

    task automatic t_long_stall();
        int n;
        run_req(32'h7000_0004, 1000, 1'b1, 1'b1, 1'b0, "R11 long stalled write", n);
        // 4 + 240*4 + 32 + 4 = 1000
        chk(n == 7, "R4", "1000-byte write count", n, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_small();
        t_pad();
        t_refuse();
        t_zero();
        t_long_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule